// File: doc/BRIEF.md
# Triggered Compare-and-Clear Unit

This block sits beside a pulse or position counter and decides, at chosen instants, whether the counter value has reached a threshold. When an instant arrives (a trigger), it compares the counter against a 16-bit threshold word. If the comparison holds, it raises a one-clock match strobe and a one-clock request that tells the counter to clear itself. The counter is outside this block.

A trigger comes from one of two sources. The first is a strobe marking ticks of a slow reference clock, thinned by a divider of 1, 2, 4 or 8. The second is a rising edge on one of eight event lines, and that line can be inverted first. The same chosen event line can also act as a level gate on counting, which is offered to the counter as an output.

The comparison can be one of three tests: at most the threshold, at least the threshold, or a window. In the window test, the threshold word holds an upper bound in its high byte and a lower bound in its low byte.

Top module: `tcc_unit`

## Requirements
- R1: While `rst_n` is low, `match_pulse` and `clear_req` are 0, and `count_gate` is 1 when `gate_en` is 0.
- R2: When `trig_mode` is 0 (off) or 3 (reserved), `match_pulse` and `clear_req` stay 0 whatever the other inputs do.
- R3: When `trig_mode` is 1 (tick trigger), a trigger occurs on every Nth cycle in which `lf_tick` is high, with N = 2^`presc_code` (code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8). The divider starts counting from zero.
- R4: In any cycle where `trig_mode` or `presc_code` differs from its value in the previous cycle, the divider count returns to zero and no tick trigger is produced in that cycle.
- R5: Compare mode 0 (`cmp_mode`=0) matches when `cnt_value` <= `top_value`.
- R6: Compare mode 1 matches when `cnt_value` >= `top_value`.
- R7: Compare mode 2 matches when `cnt_value` is at least `top_value[7:0]` and at most `top_value[15:8]`. Both bounds are zero-extended.
- R8: Compare mode 3 (reserved) never matches, so no match pulse and no clear request occur.
- R9: When `trig_mode` is 2 (event trigger), a trigger occurs in a cycle where the event line indexed by `evt_sel` is high after being low in the previous cycle. The other lines and `lf_tick` have no effect.
- R10: When `evt_invert` is 1, the selected line is inverted before edge detection, so a falling edge of the raw line triggers.
- R11: If a cycle has a trigger and the compare result is true, `match_pulse` and `clear_req` are both high for exactly the next clock cycle. Otherwise both are low in that next cycle.
- R12: `count_gate` equals the selected event line after the polarity inversion when `gate_en` is 1, and is 1 when `gate_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_tick | input | 1 | One-cycle strobe per slow reference clock tick |
| cnt_value | input | 16 | Current counter value |
| top_value | input | 16 | Threshold word, or window bounds in compare mode 2 |
| evt_lines | input | 8 | Event lines |
| trig_mode | input | 2 | 0 off, 1 tick, 2 event, 3 reserved |
| presc_code | input | 2 | Tick divider code, divide by 2^code |
| cmp_mode | input | 2 | 0 at most, 1 at least, 2 window, 3 reserved |
| evt_sel | input | 3 | Index of the selected event line |
| evt_invert | input | 1 | Invert the selected line |
| gate_en | input | 1 | Use the selected line as a count gate |
| match_pulse | output | 1 | One-cycle compare match strobe |
| clear_req | output | 1 | One-cycle counter clear request |
| count_gate | output | 1 | Count enable level offered to the counter |

## Verification
The divider restart is the hardest situation to reach from the ports. The divider count is internal, so it only shows up in the position of the next match. The stimulus runs the divider part way (five ticks at divide-by-8, or one tick at divide-by-2), then changes the divider code or steps the trigger mode out and back. It then counts how many further ticks come before the first pulse. The inversion path is just as indirect: the inversion is switched while triggers are off, so the level change it causes is absorbed before event mode is entered.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

   typedef enum logic [1:0] {
      TRIG_OFF   = 2'd0,
      TRIG_TICK  = 2'd1,
      TRIG_EVENT = 2'd2,
      TRIG_RSVD  = 2'd3
   } trig_mode_e;

   typedef enum logic [1:0] {
      CMP_AT_MOST  = 2'd0,
      CMP_AT_LEAST = 2'd1,
      CMP_WINDOW   = 2'd2,
      CMP_RSVD     = 2'd3
   } cmp_mode_e;

endpackage

// File: rtl/tcc_tick_divider.sv
module tcc_tick_divider
   import tcc_pkg::*;
#(
   parameter int PSW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           lf_tick,
   input  logic [1:0]     trig_mode,
   input  logic [PSW-1:0] presc_code,
   output logic           tick_fire
);
   localparam int CNTW = (1 << PSW) - 1;
   localparam int CFGW = 2 + PSW;

   if (PSW < 1 || PSW > 3) begin : g_bad_psw
      $error("tcc_tick_divider: PSW must be 1..3");
   end

   logic [CFGW-1:0] cfg_q;
   logic [CNTW-1:0] cnt_q;
   logic [CNTW-1:0] cnt_lim;
   logic            cfg_changed;
   logic            tick_active;

   assign cfg_changed = ({trig_mode, presc_code} != cfg_q);
   assign tick_active = (trig_mode == TRIG_TICK) && lf_tick;
   assign cnt_lim     = CNTW'((1 << presc_code) - 1);
   assign tick_fire   = tick_active && !cfg_changed && (cnt_q == cnt_lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         cnt_q <= '0;
      end else begin
         cfg_q <= {trig_mode, presc_code};
         if (cfg_changed) begin
            cnt_q <= '0;
         end else if (tick_active) begin
            cnt_q <= (cnt_q == cnt_lim) ? '0 : cnt_q + 1'b1;
         end
      end
   end

   // A fire with a divider above one restarts the count, so the next cycle cannot fire
   AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_fire && presc_code != '0 && $stable(presc_code)) |=> !tick_fire); // R3

endmodule

// File: rtl/tcc_event_select.sv
module tcc_event_select
   import tcc_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int SELW = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  evt_lines,
   input  logic [SELW-1:0] evt_sel,
   input  logic            evt_invert,
   input  logic            gate_en,
   input  logic [1:0]      trig_mode,
   output logic            evt_fire,
   output logic            count_gate
);
   if (NCH < 2) begin : g_bad_nch
      $error("tcc_event_select: NCH must be at least 2");
   end

   logic picked;
   logic lvl;
   logic lvl_q;

   if (NCH == (1 << SELW)) begin : g_full_mux
      assign picked = evt_lines[evt_sel];
   end else begin : g_part_mux
      assign picked = (int'(evt_sel) < NCH) ? evt_lines[evt_sel] : 1'b0;
   end

   assign lvl        = picked ^ evt_invert;
   assign evt_fire   = (trig_mode == TRIG_EVENT) && lvl && !lvl_q;
   assign count_gate = gate_en ? lvl : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

endmodule

// File: rtl/tcc_compare.sv
module tcc_compare
   import tcc_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic [CW-1:0] cnt_value,
   input  logic [CW-1:0] top_value,
   input  logic [1:0]    cmp_mode,
   output logic          cmp_hit
);
   localparam int HW = CW / 2;

   if (CW < 2 || (CW % 2) != 0) begin : g_bad_cw
      $error("tcc_compare: CW must be even and at least 2");
   end

   logic [CW-1:0] win_hi;
   logic [CW-1:0] win_lo;

   assign win_hi = {{(CW-HW){1'b0}}, top_value[CW-1:HW]};
   assign win_lo = {{(CW-HW){1'b0}}, top_value[HW-1:0]};

   always_comb begin
      unique case (cmp_mode)
         CMP_AT_MOST:  cmp_hit = (cnt_value <= top_value);
         CMP_AT_LEAST: cmp_hit = (cnt_value >= top_value);
         CMP_WINDOW:   cmp_hit = (cnt_value <= win_hi) && (cnt_value >= win_lo);
         default:      cmp_hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
   import tcc_pkg::*;
#(
   parameter int CW   = 16,
   parameter int NCH  = 8,
   parameter int SELW = $clog2(NCH),
   parameter int PSW  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lf_tick,
   input  logic [CW-1:0]   cnt_value,
   input  logic [CW-1:0]   top_value,
   input  logic [NCH-1:0]  evt_lines,
   input  logic [1:0]      trig_mode,
   input  logic [PSW-1:0]  presc_code,
   input  logic [1:0]      cmp_mode,
   input  logic [SELW-1:0] evt_sel,
   input  logic            evt_invert,
   input  logic            gate_en,
   output logic            match_pulse,
   output logic            clear_req,
   output logic            count_gate
);
   localparam int HW = CW / 2;

   logic tick_fire;
   logic evt_fire;
   logic any_fire;
   logic cmp_hit;

   tcc_tick_divider #(.PSW(PSW)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .lf_tick    (lf_tick),
      .trig_mode  (trig_mode),
      .presc_code (presc_code),
      .tick_fire  (tick_fire)
   );

   tcc_event_select #(.NCH(NCH), .SELW(SELW)) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_lines  (evt_lines),
      .evt_sel    (evt_sel),
      .evt_invert (evt_invert),
      .gate_en    (gate_en),
      .trig_mode  (trig_mode),
      .evt_fire   (evt_fire),
      .count_gate (count_gate)
   );

   tcc_compare #(.CW(CW)) u_cmp (
      .cnt_value (cnt_value),
      .top_value (top_value),
      .cmp_mode  (cmp_mode),
      .cmp_hit   (cmp_hit)
   );

   assign any_fire = tick_fire | evt_fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_pulse <= 1'b0;
         clear_req   <= 1'b0;
      end else begin
         match_pulse <= any_fire & cmp_hit;
         clear_req   <= any_fire & cmp_hit;
      end
   end

   AST_PULSE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> $past(any_fire)); // R11
   AST_CLEAR_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      clear_req |-> $past(cmp_hit)); // R11
   AST_IDLE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode == TRIG_OFF || trig_mode == TRIG_RSVD) |=> !match_pulse); // R2
   AST_RSVD_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_mode == CMP_RSVD) |=> !clear_req); // R8
   AST_WINDOW_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && $past(cmp_mode) == CMP_WINDOW) |->
      ($past(cnt_value) <= CW'($past(top_value[CW-1:HW])) &&
       $past(cnt_value) >= CW'($past(top_value[HW-1:0])))); // R7

endmodule

// File: tb/tcc_unit_tb.sv
module tcc_unit_tb;
   localparam int CW  = 16;
   localparam int NCH = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          lf_tick;
   logic [CW-1:0] cnt_value;
   logic [CW-1:0] top_value;
   logic [NCH-1:0] evt_lines;
   logic [1:0]    trig_mode;
   logic [1:0]    presc_code;
   logic [1:0]    cmp_mode;
   logic [2:0]    evt_sel;
   logic          evt_invert;
   logic          gate_en;
   logic          match_pulse;
   logic          clear_req;
   logic          count_gate;

   always #2 clk = ~clk;

   tcc_unit u_dut (
      .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .cnt_value(cnt_value),
      .top_value(top_value), .evt_lines(evt_lines), .trig_mode(trig_mode),
      .presc_code(presc_code), .cmp_mode(cmp_mode), .evt_sel(evt_sel),
      .evt_invert(evt_invert), .gate_en(gate_en), .match_pulse(match_pulse),
      .clear_req(clear_req), .count_gate(count_gate)
   );

   typedef struct {
      logic  exp;
      string req;
   } item_t;

   item_t sbq[$];
   int checks = 0;
   int errors = 0;

   // driver: push the expected output for the coming edge, then advance
   task automatic step(input logic exp, input string req);
      item_t it;
      it.exp = exp;
      it.req = req;
      sbq.push_back(it);
      @(negedge clk);
   endtask

   task automatic chk_gate(input logic exp, input string req);
      #1;
      checks++;
      if (count_gate !== exp) begin
         errors++;
         $display("FAIL %s count_gate actual=%0b expected=%0b", req, count_gate, exp);
      end
   endtask

   // monitor: compare outputs just after each edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (match_pulse !== it.exp || clear_req !== it.exp) begin
               errors++;
               $display("FAIL %s match=%0b clear=%0b expected=%0b",
                        it.req, match_pulse, clear_req, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      int k;
      rst_n = 1'b0; lf_tick = 1'b1; cnt_value = '0; top_value = 16'd5;
      evt_lines = '0; trig_mode = 2'd1; presc_code = '0; cmp_mode = 2'd0;
      evt_sel = '0; evt_invert = 1'b0; gate_en = 1'b0;
      repeat (3) @(negedge clk);
      checks++;
      if (match_pulse !== 1'b0 || clear_req !== 1'b0 || count_gate !== 1'b1) begin
         errors++;
         $display("FAIL R1 reset match=%0b clear=%0b gate=%0b expected=0 0 1",
                  match_pulse, clear_req, count_gate);
      end
      trig_mode = 2'd0;
      @(negedge clk);
      rst_n = 1'b1;

      // R2: off and reserved trigger modes
      for (int i = 0; i < 4; i++) step(1'b0, "R2 off");
      trig_mode = 2'd3;
      for (int i = 0; i < 4; i++) step(1'b0, "R2 reserved");

      // R3: every divider code
      lf_tick = 1'b0; trig_mode = 2'd1;
      step(1'b0, "R4 mode change");
      for (int p = 0; p < 4; p++) begin
         presc_code = 2'(p);
         lf_tick = 1'b0;
         step(1'b0, "R4 divider change");
         n = 1 << p;
         k = 0;
         for (int i = 0; i < 4 * n; i++) begin
            lf_tick = (i % 2 == 0);
            if (lf_tick) k++;
            step(lf_tick && (k % n == 0), "R3 divider");
         end
      end

      // R4: divider code change mid-count
      lf_tick = 1'b0; presc_code = 2'd3;
      step(1'b0, "R4");
      lf_tick = 1'b1;
      for (int i = 0; i < 5; i++) step(1'b0, "R4 partial");
      lf_tick = 1'b0; presc_code = 2'd2;
      step(1'b0, "R4");
      lf_tick = 1'b1;
      step(1'b0, "R4 restart"); step(1'b0, "R4 restart"); step(1'b0, "R4 restart");
      step(1'b1, "R4 restart fourth tick");
      // R4: trigger mode out and back mid-count
      lf_tick = 1'b0; presc_code = 2'd1;
      step(1'b0, "R4");
      lf_tick = 1'b1; step(1'b0, "R4 one tick");
      lf_tick = 1'b0; trig_mode = 2'd0; step(1'b0, "R4 mode out");
      trig_mode = 2'd1; step(1'b0, "R4 mode back");
      lf_tick = 1'b1; step(1'b0, "R4 first tick after restart");
      step(1'b1, "R4 second tick after restart");

      // compare modes at divide-by-1
      lf_tick = 1'b0; presc_code = 2'd0;
      step(1'b0, "R4");
      lf_tick = 1'b1;
      cmp_mode = 2'd0; top_value = 16'd100;
      cnt_value = 16'd99;  step(1'b1, "R5 below");
      cnt_value = 16'd100; step(1'b1, "R5 equal");
      cnt_value = 16'd101; step(1'b0, "R5 above");
      cmp_mode = 2'd1;
      cnt_value = 16'd99;   step(1'b0, "R6 below");
      cnt_value = 16'd100;  step(1'b1, "R6 equal");
      cnt_value = 16'd101;  step(1'b1, "R6 above");
      cnt_value = 16'hFFFF; step(1'b1, "R6 max");
      cmp_mode = 2'd2; top_value = 16'h3010;
      cnt_value = 16'h000F; step(1'b0, "R7 under low bound");
      cnt_value = 16'h0010; step(1'b1, "R7 low bound");
      cnt_value = 16'h0020; step(1'b1, "R7 inside");
      cnt_value = 16'h0030; step(1'b1, "R7 high bound");
      cnt_value = 16'h0031; step(1'b0, "R7 over high bound");
      cnt_value = 16'h1010; step(1'b0, "R7 far above");
      cmp_mode = 2'd3;
      cnt_value = 16'h0020; step(1'b0, "R8 reserved compare");
      cnt_value = 16'h0000; top_value = 16'hFFFF; step(1'b0, "R8 reserved compare");

      // R9: event trigger
      lf_tick = 1'b0; trig_mode = 2'd2; cmp_mode = 2'd1;
      top_value = 16'd10; cnt_value = 16'd20; evt_sel = 3'd5; evt_lines = '0;
      step(1'b0, "R9 enter event mode");
      evt_lines[5] = 1'b1; step(1'b1, "R9 rising edge");
      step(1'b0, "R11 single pulse on held level");
      evt_lines = 8'hFF; step(1'b0, "R9 other lines ignored");
      evt_lines = 8'h20; step(1'b0, "R9 other lines ignored");
      lf_tick = 1'b1; step(1'b0, "R9 tick ignored");
      lf_tick = 1'b0;
      evt_lines[5] = 1'b0; step(1'b0, "R9 falling edge");
      cnt_value = 16'd5;
      evt_lines[5] = 1'b1; step(1'b0, "R9 edge without compare hit");
      evt_lines[5] = 1'b0; cnt_value = 16'd20; evt_sel = 3'd2;
      step(1'b0, "R9 select change");
      evt_lines[2] = 1'b1; step(1'b1, "R9 new channel edge");
      evt_lines = '0; step(1'b0, "R9");

      // R10: inverted polarity
      trig_mode = 2'd0; step(1'b0, "R10 setup");
      evt_invert = 1'b1; step(1'b0, "R10 setup");
      trig_mode = 2'd2; step(1'b0, "R10 enter event mode");
      evt_lines[2] = 1'b1; step(1'b0, "R10 raw rising ignored");
      evt_lines[2] = 1'b0; step(1'b1, "R10 raw falling triggers");

      // R12: gate output
      trig_mode = 2'd0; step(1'b0, "R12 setup");
      gate_en = 1'b0; chk_gate(1'b1, "R12 gate disabled");
      evt_lines[2] = 1'b1; chk_gate(1'b1, "R12 gate disabled");
      gate_en = 1'b1; chk_gate(1'b0, "R12 inverted high line");
      evt_invert = 1'b0; chk_gate(1'b1, "R12 plain high line");
      evt_lines[2] = 1'b0; chk_gate(1'b0, "R12 plain low line");
      evt_lines[3] = 1'b1; chk_gate(1'b0, "R12 other line ignored");

      @(negedge clk);
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule